// File: doc/BRIEF.md
# Per-Channel Requantizer With Clip Detection

This block narrows channelized complex samples to a 4-bit real and a 4-bit imaginary value before correlation. Each sample's two 18-bit signed parts are multiplied by a gain looked up from a table indexed by the sample's channel number. The product is rounded and then saturated into one byte. A per-sample clip flag and a per-integration clip total show which data overloaded the narrow output. An optional headroom mode limits each part to a 3-bit range, so one bit of margin stays unused.

The gain table has a write port. Writes never change a gain while a spectrum is in flight. A write that arrives during a spectrum waits in a small pending queue. It is committed after the spectrum's last sample has passed.

Top module: `chan_requant`

## Requirements
- R1: A sample presented with `s_valid` high at a clock edge appears with `q_valid` high two clock edges later. `q_valid` is low at all other times, including after reset.
- R2: `q_byte[7:4]` holds the real result and `q_byte[3:0]` holds the imaginary result, each in two's complement. The code 4'b1000 (-8) never appears.
- R3: Each part is computed as x*g/2^18 and rounded half away from zero. Here x is the signed input and g is the unsigned 12-bit gain with 8 fraction bits (256 = unity). For example, at unity gain 512 becomes 1, 511 becomes 0, -512 becomes -1 and 1536 becomes 2.
- R4: A rounded magnitude above the limit is replaced by the limit with the sign kept. The limit is 7 in normal mode. `q_clip` is high with a result exactly when either part was limited.
- R5: When `headroom` is high with a sample, the limit for that sample is 3 instead of 7.
- R6: Every channel's gain is unity after reset, and each channel uses its own table entry.
- R7: A gain write in a cycle with no sample and no open spectrum takes effect for a sample in the next cycle. A spectrum opens on a sample with `s_first` high and closes on a sample with `s_last` high.
- R8: A gain write made while a spectrum is open, or in a cycle carrying a sample, does not affect that spectrum. It is committed after the spectrum closes, during cycles without samples. Writes are committed in arrival order, so a later write to the same channel wins.
- R9: Up to four deferred writes wait at once. A write arriving while four are already waiting is discarded.
- R10: The block counts the output samples that had a clip. One cycle after the result of a sample flagged with `s_int_end`, `clip_tot` shows the count for that integration, including that sample, and `clip_tot_valid` pulses for one cycle. The count then restarts from zero. `clip_tot` holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Sample present |
| s_chan | input | 6 | Channel number of the sample |
| s_re | input | 18 | Real part, signed |
| s_im | input | 18 | Imaginary part, signed |
| s_first | input | 1 | First sample of a spectrum |
| s_last | input | 1 | Last sample of a spectrum |
| s_int_end | input | 1 | Last sample of an integration |
| headroom | input | 1 | Limit this sample to the 3-bit range |
| g_wr | input | 1 | Gain write strobe |
| g_addr | input | 6 | Channel to write |
| g_val | input | 12 | Gain value, 8 fraction bits |
| q_valid | output | 1 | Result present |
| q_byte | output | 8 | Packed real and imaginary result |
| q_clip | output | 1 | Either part of this result was limited |
| clip_tot | output | 16 | Clip count of the last finished integration (saturating) |
| clip_tot_valid | output | 1 | One-cycle pulse when `clip_tot` updates |

## Verification
The assertions assume that `headroom` is held with its sample for the cycle in which that sample is presented. They also assume that `s_first` and `s_last` are only meaningful when `s_valid` is high. The stimulus therefore raises `headroom`, `s_first`, `s_last` and `s_int_end` only together with `s_valid` and drops them with it. Gain writes are issued only from separate cycles of their own, so every write is either clearly outside a spectrum or clearly inside one. Spectra are always closed, and enough idle cycles follow each one for the deferred writes to drain before the gains are probed.

// File: rtl/requant_pkg.sv
package requant_pkg;

    localparam int QW       = 4;
    localparam int FULL_LIM = 7;
    localparam int HEAD_LIM = 3;

    typedef struct packed {
        logic signed [QW-1:0] re;
        logic signed [QW-1:0] im;
    } qpair_t;

    typedef struct packed {
        logic valid;
        logic headroom;
        logic int_end;
    } smp_tag_t;

    function automatic logic [QW-1:0] q_limit(input logic hr);
        return hr ? QW'(HEAD_LIM) : QW'(FULL_LIM);
    endfunction

endpackage

// File: rtl/gain_table.sv
module gain_table #(
    parameter int NUM_CHAN   = 64,
    parameter int GAIN_W     = 12,
    parameter int PEND_DEPTH = 4,
    parameter int UNITY      = 256,
    localparam int CH_W      = $clog2(NUM_CHAN),
    localparam int PTR_W     = $clog2(PEND_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic [CH_W-1:0]   rd_chan,
    output logic [GAIN_W-1:0] rd_gain,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_addr,
    input  logic [GAIN_W-1:0] wr_val,
    output logic              commit_we
);
    logic [GAIN_W-1:0] tbl [NUM_CHAN];
    logic [CH_W-1:0]   pend_addr [PEND_DEPTH];
    logic [GAIN_W-1:0] pend_val  [PEND_DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [PTR_W:0]    pend_cnt;

    logic direct, push, pop;
    logic [CH_W-1:0]   c_addr;
    logic [GAIN_W-1:0] c_val;

    always_comb begin
        direct    = wr_en && !busy && (pend_cnt == '0);
        push      = wr_en && !direct && (pend_cnt != (PTR_W+1)'(PEND_DEPTH));
        pop       = !busy && (pend_cnt != '0);
        commit_we = direct || pop;
        c_addr    = pop ? pend_addr[rd_ptr] : wr_addr;
        c_val     = pop ? pend_val[rd_ptr]  : wr_val;
    end

    assign rd_gain = tbl[rd_chan];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CHAN; i++) tbl[i] <= GAIN_W'(UNITY);
        end else if (commit_we) begin
            tbl[c_addr] <= c_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            pend_cnt <= '0;
            for (int i = 0; i < PEND_DEPTH; i++) begin
                pend_addr[i] <= '0;
                pend_val[i]  <= '0;
            end
        end else begin
            if (push) begin
                pend_addr[wr_ptr] <= wr_addr;
                pend_val[wr_ptr]  <= wr_val;
                wr_ptr            <= wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   pend_cnt <= pend_cnt + 1'b1;
                2'b01:   pend_cnt <= pend_cnt - 1'b1;
                default: pend_cnt <= pend_cnt;
            endcase
        end
    end

endmodule

// File: rtl/requant_lane.sv
module requant_lane
    import requant_pkg::*;
#(
    parameter int IN_W   = 18,
    parameter int GAIN_W = 12,
    parameter int DROP   = 18,
    localparam int PW    = IN_W + GAIN_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [IN_W-1:0]  smp,
    input  logic [GAIN_W-1:0]       gain,
    input  logic                    headroom_s1,
    output logic signed [QW-1:0]    q,
    output logic                    clip
);
    localparam logic [PW:0] HALF = (PW+1)'(1) << (DROP-1);

    logic signed [PW-1:0] a_ext, g_ext, prod_r;
    logic                 neg, clip_c;
    logic [PW-1:0]        mag;
    logic [PW:0]          rnd;
    logic [QW-1:0]        lim, m;
    logic signed [QW-1:0] q_c;

    assign a_ext = PW'(smp);
    assign g_ext = $signed(PW'({1'b0, gain}));

    always_ff @(posedge clk) begin
        if (rst) prod_r <= '0;
        else     prod_r <= a_ext * g_ext;
    end

    always_comb begin
        neg    = prod_r[PW-1];
        mag    = neg ? PW'(-prod_r) : PW'(prod_r);
        rnd    = ({1'b0, mag} + HALF) >> DROP;
        lim    = q_limit(headroom_s1);
        clip_c = rnd > (PW+1)'(lim);
        m      = clip_c ? lim : rnd[QW-1:0];
        q_c    = neg ? -$signed(m) : $signed(m);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            clip <= 1'b0;
        end else begin
            q    <= q_c;
            clip <= clip_c;
        end
    end

endmodule

// File: rtl/clip_tally.sv
module clip_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             clip_any,
    input  logic             int_end,
    output logic [CNT_W-1:0] total,
    output logic             total_valid
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] run, run_inc;

    assign run_inc = (valid && clip_any && run != CMAX) ? run + 1'b1 : run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run         <= '0;
            total       <= '0;
            total_valid <= 1'b0;
        end else begin
            total_valid <= valid && int_end;
            if (valid && int_end) begin
                total <= run_inc;
                run   <= '0;
            end else begin
                run   <= run_inc;
            end
        end
    end

endmodule

// File: rtl/chan_requant.sv
module chan_requant
    import requant_pkg::*;
#(
    parameter int NUM_CHAN   = 64,
    parameter int IN_W       = 18,
    parameter int GAIN_W     = 12,
    parameter int GAIN_FRAC  = 8,
    parameter int IN_SHIFT   = 10,
    parameter int PEND_DEPTH = 4,
    parameter int CNT_W      = 16,
    localparam int CH_W      = $clog2(NUM_CHAN)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   s_valid,
    input  logic [CH_W-1:0]        s_chan,
    input  logic signed [IN_W-1:0] s_re,
    input  logic signed [IN_W-1:0] s_im,
    input  logic                   s_first,
    input  logic                   s_last,
    input  logic                   s_int_end,
    input  logic                   headroom,
    input  logic                   g_wr,
    input  logic [CH_W-1:0]        g_addr,
    input  logic [GAIN_W-1:0]      g_val,
    output logic                   q_valid,
    output logic [2*QW-1:0]        q_byte,
    output logic                   q_clip,
    output logic [CNT_W-1:0]       clip_tot,
    output logic                   clip_tot_valid
);
    localparam int DROP = GAIN_FRAC + IN_SHIFT;

    logic              spec_open, busy, commit_we;
    logic [GAIN_W-1:0] cur_gain;
    smp_tag_t          tag1, tag2;
    qpair_t            qp;
    logic signed [IN_W-1:0] part_in  [2];
    logic signed [QW-1:0]   part_q   [2];
    logic                   part_clip[2];

    always_ff @(posedge clk) begin
        if (rst)          spec_open <= 1'b0;
        else if (s_valid) begin
            if (s_last)       spec_open <= 1'b0;
            else if (s_first) spec_open <= 1'b1;
        end
    end

    assign busy = spec_open || s_valid;

    gain_table #(
        .NUM_CHAN(NUM_CHAN), .GAIN_W(GAIN_W),
        .PEND_DEPTH(PEND_DEPTH), .UNITY(1 << GAIN_FRAC)
    ) u_gtab (
        .clk(clk), .rst(rst), .busy(busy),
        .rd_chan(s_chan), .rd_gain(cur_gain),
        .wr_en(g_wr), .wr_addr(g_addr), .wr_val(g_val),
        .commit_we(commit_we)
    );

    assign part_in[0] = s_re;
    assign part_in[1] = s_im;

    for (genvar gi = 0; gi < 2; gi++) begin : g_part
        requant_lane #(.IN_W(IN_W), .GAIN_W(GAIN_W), .DROP(DROP)) u_lane (
            .clk(clk), .rst(rst),
            .smp(part_in[gi]), .gain(cur_gain),
            .headroom_s1(tag1.headroom),
            .q(part_q[gi]), .clip(part_clip[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag1 <= '0;
            tag2 <= '0;
        end else begin
            tag1 <= '{valid: s_valid, headroom: headroom, int_end: s_valid && s_int_end};
            tag2 <= tag1;
        end
    end

    assign qp.re   = part_q[0];
    assign qp.im   = part_q[1];
    assign q_valid = tag2.valid;
    assign q_byte  = tag2.valid ? qp : '0;
    assign q_clip  = tag2.valid && (part_clip[0] || part_clip[1]);

    clip_tally #(.CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst(rst),
        .valid(tag2.valid), .clip_any(q_clip), .int_end(tag2.int_end),
        .total(clip_tot), .total_valid(clip_tot_valid)
    );

endmodule

// File: rtl/requant_chk.sv
module requant_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             s_valid,
    input logic             headroom,
    input logic             q_valid,
    input logic [7:0]       q_byte,
    input logic             q_clip,
    input logic [CNT_W-1:0] clip_tot,
    input logic             clip_tot_valid,
    input logic             spec_open,
    input logic             commit_we
);
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        s_valid |-> ##2 q_valid);

    a_r2_no_minus8: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> (q_byte[7:4] != 4'b1000 && q_byte[3:0] != 4'b1000));

    a_r4_clip_needs_valid: assert property (@(posedge clk) disable iff (rst)
        q_clip |-> q_valid);

    a_r5_headroom_range: assert property (@(posedge clk) disable iff (rst)
        (q_valid && $past(headroom, 2)) |->
            ($signed(q_byte[7:4]) >= -4'sd3 && $signed(q_byte[7:4]) <= 4'sd3 &&
             $signed(q_byte[3:0]) >= -4'sd3 && $signed(q_byte[3:0]) <= 4'sd3));

    a_r8_no_commit_in_spectrum: assert property (@(posedge clk) disable iff (rst)
        spec_open |-> !commit_we);

    a_r10_total_holds: assert property (@(posedge clk) disable iff (rst)
        !clip_tot_valid |-> $stable(clip_tot));

endmodule

bind chan_requant requant_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .s_valid(s_valid), .headroom(headroom),
    .q_valid(q_valid), .q_byte(q_byte), .q_clip(q_clip),
    .clip_tot(clip_tot), .clip_tot_valid(clip_tot_valid),
    .spec_open(spec_open), .commit_we(commit_we)
);

// File: tb/test_chan_requant.sv
module test_chan_requant;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               s_valid = 0, s_first = 0, s_last = 0, s_int_end = 0, headroom = 0;
    logic [5:0]         s_chan = '0;
    logic signed [17:0] s_re = '0, s_im = '0;
    logic               g_wr = 0;
    logic [5:0]         g_addr = '0;
    logic [11:0]        g_val = '0;
    logic               q_valid, q_clip, clip_tot_valid;
    logic [7:0]         q_byte;
    logic [15:0]        clip_tot;

    always #4 clk = ~clk;

    chan_requant i_chan_requant (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_chan(s_chan),
        .s_re(s_re), .s_im(s_im), .s_first(s_first), .s_last(s_last),
        .s_int_end(s_int_end), .headroom(headroom),
        .g_wr(g_wr), .g_addr(g_addr), .g_val(g_val),
        .q_valid(q_valid), .q_byte(q_byte), .q_clip(q_clip),
        .clip_tot(clip_tot), .clip_tot_valid(clip_tot_valid)
    );

    typedef struct {
        logic [7:0] b;
        logic       c;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   tot_q[$];
    int   total = 0, bad = 0, clip_run = 0;
    bit   done = 0;

    function automatic int qpart(input int x, input int g, input bit hr, output bit c);
        int p, mag, r, lim;
        p   = x * g;
        mag = (p < 0) ? -p : p;
        r   = (mag + (1 << 17)) >>> 18;
        lim = hr ? 3 : 7;
        c   = (r > lim);
        if (c) r = lim;
        return (p < 0) ? -r : r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic smp(input int ch, input int re, input int im, input int g,
                       input bit hr, input bit first, input bit last, input bit ie,
                       input string req);
        exp_t e;
        bit cr, ci;
        int vr, vi;
        vr    = qpart(re, g, hr, cr);
        vi    = qpart(im, g, hr, ci);
        e.b   = {vr[3:0], vi[3:0]};
        e.c   = cr | ci;
        e.req = req;
        exp_q.push_back(e);
        if (e.c) clip_run++;
        if (ie) begin
            tot_q.push_back(clip_run);
            clip_run = 0;
        end
        s_valid = 1; s_chan = 6'(ch); s_re = 18'(re); s_im = 18'(im);
        headroom = hr; s_first = first; s_last = last; s_int_end = ie;
        @(posedge clk); #1;
        s_valid = 0; headroom = 0; s_first = 0; s_last = 0; s_int_end = 0;
    endtask

    task automatic wr(input int ch, input int g);
        g_wr = 1; g_addr = 6'(ch); g_val = 12'(g);
        @(posedge clk); #1;
        g_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (q_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R1 unexpected result", int'(q_byte), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(q_byte == e.b, e.req, int'(q_byte), int'(e.b));
                    check(q_clip == e.c, {e.req, " clip flag R4"}, int'(q_clip), int'(e.c));
                end
            end
            if (clip_tot_valid) begin
                if (tot_q.size() == 0) begin
                    check(0, "R10 unexpected total", int'(clip_tot), -1);
                end else begin
                    int t;
                    t = tot_q.pop_front();
                    check(int'(clip_tot) == t, "R10 clip total", int'(clip_tot), t);
                end
            end
        end
    end

    task automatic finish_run;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #800000;
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(q_valid == 0, "R1 reset q_valid", int'(q_valid), 0);
        check(clip_tot == 0, "R10 reset clip_tot", int'(clip_tot), 0);
        @(posedge clk); #1;
        rst = 0;
        idle(2);

        // R3 rounding at unity gain (R6 reset gain), packing R2
        smp(0,  512,  511, 256, 0, 0, 0, 0, "R3 half up / below half");
        smp(1, -512, -511, 256, 0, 0, 0, 0, "R3 negative half away");
        smp(2, 1536, -1536, 256, 0, 0, 0, 0, "R3 1.5 to 2");
        smp(3, 7168, -7679, 256, 0, 0, 0, 0, "R2 R4 edge of range");
        smp(4, 7680, 0, 256, 0, 0, 0, 0, "R4 just above limit");
        smp(5, -131072, 131071, 256, 0, 0, 0, 1, "R2 R4 extremes, no -8");
        idle(4);

        // R5 headroom
        smp(6, 4096, -3072, 256, 1, 0, 0, 0, "R5 limit 3");
        smp(7, -8192, 2048, 256, 1, 0, 0, 1, "R5 negative limit");
        idle(4);

        // R7 direct write, R6 per-channel independence
        wr(3, 512);
        smp(3, 1024, -1024, 512, 0, 0, 0, 0, "R7 new gain next sample");
        smp(4, 1024, 1024, 256, 0, 0, 0, 0, "R6 other channel untouched");
        idle(3);

        // R8 deferred writes within a spectrum
        smp(0, 1024, 0, 256, 0, 1, 0, 0, "R8 spectrum start");
        wr(5, 768);
        wr(7, 512);
        wr(7, 1024);
        smp(5, 2048, 0, 256, 0, 0, 0, 0, "R8 old gain within spectrum");
        smp(7, 1024, 0, 256, 0, 0, 1, 0, "R8 old gain at last sample");
        idle(6);
        smp(5, 2048, -2048, 768, 0, 0, 0, 0, "R8 deferred gain applied");
        smp(7, 1024, 1024, 1024, 0, 0, 0, 1, "R8 arrival order");
        idle(4);

        // R9 pending capacity
        smp(0, 0, 0, 256, 0, 1, 0, 0, "R9 spectrum start");
        wr(10, 512);
        wr(11, 512);
        wr(12, 512);
        wr(13, 512);
        wr(14, 512);
        smp(1, 0, 0, 256, 0, 0, 1, 0, "R9 spectrum end");
        idle(8);
        smp(13, 1024, 0, 512, 0, 0, 0, 0, "R9 fourth write kept");
        smp(14, 1024, 0, 256, 0, 0, 0, 0, "R9 fifth write dropped");
        idle(3);

        // R10 clip count over an integration, then restart at zero
        smp(20, 100000, 0, 256, 0, 0, 0, 0, "R10 clip a");
        smp(21, 0, -100000, 256, 0, 0, 0, 0, "R10 clip b");
        smp(22, 1024, 1024, 256, 0, 0, 0, 0, "R10 no clip");
        smp(23, 90000, 90000, 256, 0, 0, 0, 1, "R10 clip at boundary");
        smp(24, 1024, 0, 256, 0, 0, 0, 0, "R10 fresh integration");
        smp(25, -2048, 0, 256, 0, 0, 0, 1, "R10 zero clips");
        idle(6);

        check(exp_q.size() == 0, "R1 all results seen", exp_q.size(), 0);
        check(tot_q.size() == 0, "R10 all totals seen", tot_q.size(), 0);
        finish_run();
    end

endmodule